// File: doc/BRIEF.md
# Banked Dual-Write Register File

This block is a 64-entry register file of 64-bit words that accepts two writes and serves two reads in every clock cycle. It does not use a storage array with two write ports. Storage is split into four banks of sixteen words, and each bank takes at most one write per cycle. The low two bits of a register number pick the bank and the remaining bits pick the word inside it. Registers that are next to each other in numbering therefore sit in different banks.

When both write ports aim at the same bank in one cycle, port A wins and port B's data is dropped. A combinational conflict flag is raised in that cycle so that an outside scheduler can replay the write. A pair mode redirects write port B, or read port B, to the partner of port A's register, which is that register number with bit 0 flipped. A pair always spans two banks, so a paired write never raises the conflict flag. Register 0 always reads as zero and ignores writes.

Top module: `bank4_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero. From the first cycle after reset, every address reads zero on both read ports.
- R2: The file holds 64 registers of 64 bits each. Register number bits [1:0] select one of four banks, and bits [5:2] select the word within that bank.
- R3: When both write ports are enabled and their target registers lie in different banks, both words are stored at the rising edge. Both are readable in the following cycle.
- R4: When both write ports are enabled and their targets share the same bank (equal bits [1:0]), `wr_conflict` is high in that same cycle. Port A's write is stored and port B's write is discarded. In all other cases `wr_conflict` is low.
- R5: When both write ports name the same register, the value from port A is the one stored.
- R6: A write to register 0 has no effect, and reading register 0 returns zero on either read port.
- R7: With `wr_pair` high, write port B targets register `wr_a_addr ^ 1` and `wr_b_addr` is ignored. Such a paired write never raises `wr_conflict`.
- R8: With `rd_pair` high, read port B returns register `rd_a_addr ^ 1` and `rd_b_addr` is ignored.
- R9: Reads are combinational from stored contents. A read of a register in the same cycle it is written returns the value it held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 6 | Read port A register number |
| rd_b_addr | input | 6 | Read port B register number (unused when rd_pair is high) |
| rd_pair | input | 1 | Read port B returns the partner of rd_a_addr |
| rd_a_data | output | 64 | Read port A data |
| rd_b_data | output | 64 | Read port B data |
| wr_a_en | input | 1 | Write port A enable |
| wr_a_addr | input | 6 | Write port A register number |
| wr_a_data | input | 64 | Write port A data |
| wr_b_en | input | 1 | Write port B enable |
| wr_b_addr | input | 6 | Write port B register number (unused when wr_pair is high) |
| wr_b_data | input | 64 | Write port B data |
| wr_pair | input | 1 | Write port B targets the partner of wr_a_addr |
| wr_conflict | output | 1 | Both writes fell in one bank this cycle; port B was dropped |

## Verification
Two functions can fall in the same cycle: a write on each port, and a read of the registers being written. The bench sweeps every pairing of the two write addresses, 4096 cases, with both ports enabled. In each write cycle it points the read ports at the same two registers. It judges the conflict flag and the old read values within that cycle, and it judges which writes stuck on the next cycle, using a shadow model driven only by the bank rule. A second sweep repeats the exercise with pair mode on both the write and the read side.

// File: rtl/bank4_regfile.sv
module bank4_regfile #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 64,
  parameter int NBANKS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_a_addr,
  input  logic [$clog2(NREGS)-1:0] rd_b_addr,
  input  logic                     rd_pair,
  output logic [DATA_W-1:0]        rd_a_data,
  output logic [DATA_W-1:0]        rd_b_data,
  input  logic                     wr_a_en,
  input  logic [$clog2(NREGS)-1:0] wr_a_addr,
  input  logic [DATA_W-1:0]        wr_a_data,
  input  logic                     wr_b_en,
  input  logic [$clog2(NREGS)-1:0] wr_b_addr,
  input  logic [DATA_W-1:0]        wr_b_data,
  input  logic                     wr_pair,
  output logic                     wr_conflict
);
  localparam int AW    = $clog2(NREGS);
  localparam int BW    = $clog2(NBANKS);
  localparam int DEPTH = NREGS / NBANKS;

  logic [DATA_W-1:0] store_q [NBANKS][DEPTH];
  logic [AW-1:0]     rd_b_sel;
  logic [AW-1:0]     wr_b_sel;
  logic              wa_go;
  logic              wb_go;

  assign rd_b_sel = rd_pair ? (rd_a_addr ^ AW'(1)) : rd_b_addr;
  assign wr_b_sel = wr_pair ? (wr_a_addr ^ AW'(1)) : wr_b_addr;

  assign wr_conflict = wr_a_en && wr_b_en &&
                       (wr_a_addr[BW-1:0] == wr_b_sel[BW-1:0]);

  assign wa_go = wr_a_en && (wr_a_addr != '0);
  assign wb_go = wr_b_en && !wr_conflict && (wr_b_sel != '0);

  function automatic logic [DATA_W-1:0] fetch(input logic [AW-1:0] a);
    return (a == '0) ? '0 : store_q[a[BW-1:0]][a[AW-1:BW]];
  endfunction

  assign rd_a_data = fetch(rd_a_addr);
  assign rd_b_data = fetch(rd_b_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANKS; b++)
        for (int e = 0; e < DEPTH; e++)
          store_q[b][e] <= '0;
    end else begin
      if (wa_go) store_q[wr_a_addr[BW-1:0]][wr_a_addr[AW-1:BW]] <= wr_a_data;
      if (wb_go) store_q[wr_b_sel[BW-1:0]][wr_b_sel[AW-1:BW]]   <= wr_b_data;
    end
  end
endmodule

// File: rtl/bank4_regfile_chk.sv
module bank4_regfile_chk #(
  parameter int DATA_W = 64,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     rd_a_addr,
  input logic [AW-1:0]     rd_b_addr,
  input logic              rd_pair,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_a_en,
  input logic [AW-1:0]     wr_a_addr,
  input logic [DATA_W-1:0] wr_a_data,
  input logic              wr_b_en,
  input logic [AW-1:0]     wr_b_addr,
  input logic [DATA_W-1:0] wr_b_data,
  input logic              wr_pair,
  input logic              wr_conflict
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R3
  a_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_a_en && wr_a_addr != '0) ##1 (rd_a_addr == $past(wr_a_addr))
      |-> rd_a_data == $past(wr_a_data));

  // R6
  r0_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_addr == '0 |-> rd_a_data == '0);

  // R6
  r0_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_pair && rd_b_addr == '0) |-> rd_b_data == '0);

  // R7
  pair_no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pair |-> !wr_conflict);

  // R7
  pair_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_pair && wr_b_en && wr_a_addr != AW'(1)) ##1
    (rd_pair && rd_a_addr == $past(wr_a_addr))
      |-> rd_b_data == $past(wr_b_data));

  // R8
  pair_read_r0_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pair && rd_a_addr == AW'(1)) |-> rd_b_data == '0);

  // R4
  conflict_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    wr_conflict |-> (wr_a_en && wr_b_en));
endmodule

bind bank4_regfile bank4_regfile_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (.*);

// File: tb/test_bank4_regfile.sv
`timescale 1ns/1ps
module test_bank4_regfile;
  logic        clk = 0;
  logic        rst;
  logic [5:0]  rd_a_addr, rd_b_addr, wr_a_addr, wr_b_addr;
  logic        rd_pair, wr_pair, wr_a_en, wr_b_en;
  logic [63:0] rd_a_data, rd_b_data, wr_a_data, wr_b_data;
  logic        wr_conflict;

  bank4_regfile i_bank4_regfile (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] model [64];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] patt(input int k);
    return 64'h9E3779B97F4A7C15 * 64'(k + 1) ^ 64'(k);
  endfunction

  task automatic idle();
    wr_a_en = 0; wr_b_en = 0; wr_pair = 0; rd_pair = 0;
  endtask

  task automatic check_all_zero(input string tag);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      rd_a_addr = 6'(a); rd_b_addr = 6'(63 - a); rd_pair = 0;
      #1;
      check(rd_a_data, 64'd0, tag);
      check(rd_b_data, 64'd0, tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    idle();
    rst = 1; rd_a_addr = 0; rd_b_addr = 0;
    wr_a_addr = 0; wr_b_addr = 0; wr_a_data = 0; wr_b_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int a = 0; a < 64; a++) model[a] = 0;

    // R1: reset state
    check_all_zero("R1 reset");

    // R2 R3: fill every register with disjoint-bank pairs (2i, 2i+1)
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wr_a_en = 1; wr_a_addr = 6'(2*i);     wr_a_data = patt(2*i);
      wr_b_en = 1; wr_b_addr = 6'(2*i + 1); wr_b_data = patt(2*i + 1);
      #1 check({63'd0, wr_conflict}, 64'd0, "R3 no conflict across banks");
      @(negedge clk);
      idle();
      if (i != 0) model[2*i] = patt(2*i);
      model[2*i + 1] = patt(2*i + 1);
    end
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      rd_a_addr = 6'(a); rd_b_addr = 6'(a ^ 6'h3C);
      #1;
      check(rd_a_data, model[a], "R2 bank mapping read A");
      check(rd_b_data, model[a ^ 6'h3C], "R2 bank mapping read B");
    end
    check(rd_a_data, model[63], "R6 sanity");

    // R3 R4 R5 R6 R9: exhaustive address pairing
    k = 100;
    for (int aa = 0; aa < 64; aa++) begin
      for (int ab = 0; ab < 64; ab++) begin
        logic exp_c;
        @(negedge clk);
        wr_a_en = 1; wr_a_addr = 6'(aa); wr_a_data = patt(k);
        wr_b_en = 1; wr_b_addr = 6'(ab); wr_b_data = ~patt(k + 7);
        rd_a_addr = 6'(aa); rd_b_addr = 6'(ab);
        exp_c = (aa[1:0] == ab[1:0]);
        #1;
        check({63'd0, wr_conflict}, {63'd0, exp_c}, "R4 conflict flag");
        check(rd_a_data, model[aa], "R9 old value port A");
        check(rd_b_data, model[ab], "R9 old value port B");
        @(negedge clk);
        idle();
        if (aa != 0) model[aa] = patt(k);
        if (!exp_c && ab != 0) model[ab] = ~patt(k + 7);
        #1;
        check(rd_a_data, model[aa], "R5 R6 stored A");
        check(rd_b_data, model[ab], "R3 R4 stored B");
        k++;
      end
    end

    // R7 R8: paired writes and reads, wr_b_addr/rd_b_addr held at junk
    for (int aa = 0; aa < 64; aa++) begin
      @(negedge clk);
      wr_pair = 1;
      wr_a_en = 1; wr_a_addr = 6'(aa);  wr_a_data = patt(k);
      wr_b_en = 1; wr_b_addr = 6'(aa);  wr_b_data = patt(k + 3) ^ 64'hFF;
      #1 check({63'd0, wr_conflict}, 64'd0, "R7 pair never conflicts");
      @(negedge clk);
      idle();
      if (aa != 0) model[aa] = patt(k);
      if ((aa ^ 1) != 0) model[aa ^ 1] = patt(k + 3) ^ 64'hFF;
      rd_pair = 1; rd_a_addr = 6'(aa); rd_b_addr = 6'(aa ^ 6'h20);
      #1;
      check(rd_a_data, model[aa], "R7 pair A stored");
      check(rd_b_data, model[aa ^ 1], "R8 pair read partner");
      k++;
    end

    // R6: write-enable low and R0 target leave contents alone
    @(negedge clk);
    wr_a_en = 0; wr_a_addr = 6'd5; wr_a_data = 64'hDEAD;
    wr_b_en = 1; wr_b_addr = 6'd0; wr_b_data = 64'hBEEF;
    @(negedge clk);
    idle(); rd_a_addr = 6'd5; rd_b_addr = 6'd0;
    #1;
    check(rd_a_data, model[5], "R3 disabled write ignored");
    check(rd_b_data, 64'd0, "R6 R0 write ignored");

    // R1: reset after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check_all_zero("R1 reset after writes");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule